// File: doc/BRIEF.md
# Six-Channel Serial Audio Frame Deserializer

This block converts one serial audio data line into parallel channel samples. It runs directly on the bit clock, which is 256 times the sample rate, so one frame lasts exactly 256 bit periods. A frame-sync input marks where each frame, or each half-frame, begins. Six channel samples are recovered from every frame, in the order A1, A2, A3, B1, B2, B3 (channel index 0 to 5).

A mode input selects one of two framings. In split-frame mode the sync is a square wave at the sample rate. Its high half carries channels A1 to A3 and its low half carries B1 to B3. Each channel uses a 24-bit slot, and the slots sit back to back from the start of each half. In TDM mode the sync is a short pulse, and six 32-bit slots follow it in sequence. A length input selects how many leading bits of each slot form the sample. Samples leave on a shared data bus, with a one-hot strobe that names the channel. A sticky flag reports a sync that arrives somewhere other than where the 256-bit frame count expects it.

Top module: `slot_audio_rx`

## Requirements
- R1: On every rising edge of `clk` one bit of `sdin` is captured, most significant bit first, and the frame position advances by one, wrapping every 256 bits.
- R2: With `modeTdm`=0, a 0-to-1 change of `lrck` seen at an edge makes the bit captured at that edge frame bit 0, and a 1-to-0 change makes it frame bit 128. Slots of 24 bits begin at offsets 0, 24 and 48 of each half: the first half carries channels 0, 1, 2 and the second half carries channels 3, 4, 5.
- R3: With `modeTdm`=1, an edge that sees `lrck` go from 0 to 1 makes the next captured bit frame bit 0. Channel c occupies bits 32c to 32c+31 for c = 0 to 5, and bits 192 to 255 produce no sample.
- R4: `lenSel` picks the kept length: 0 is 16 bits, 1 is 18, 2 is 20, 3 is 24, and 4 to 7 are 32. In split-frame mode any length above 24 is cut to 24. Only the first kept bits of a slot form the sample, and the later bits of that slot have no effect on it.
- R5: `outData` holds the sample left-aligned in 32 bits, with every bit below the kept length zero.
- R6: `outValid[c]` is high for exactly one cycle per slot of channel c. It rises on the rising edge that captures the slot's last kept bit, and `outData` is valid in that same cycle. At most one bit of `outValid` is ever high.
- R7: `frameStart` is high exactly in the cycles where `outValid[0]` is high.
- R8: After reset, no strobe is produced until the first sync has been seen.
- R9: When the frame count is already running and a sync arrives at a position other than the expected one, `frameErr` is set and stays set until reset, and the frame position is re-aligned to that sync.
- R10: After a misplaced 1-to-0 change in split-frame mode, no strobe is produced until the next frame start.
- R11: While `rstN` is low, `outData`, `outValid`, `frameStart` and `frameErr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, 256 times the sample rate; data is captured on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| lrck | input | 1 | Frame sync: a square wave in split-frame mode, a pulse in TDM mode |
| sdin | input | 1 | Serial audio data, MSB first |
| modeTdm | input | 1 | 0 selects split-frame 24-bit slots, 1 selects TDM 32-bit slots |
| lenSel | input | 3 | Kept sample length code (see R4) |
| outData | output | OUT_W | Left-aligned sample of the channel that is strobed |
| outValid | output | 6 | One-hot strobe per channel, A1 is bit 0 and B3 is bit 5 |
| frameStart | output | 1 | Marks the A1 sample of each frame |
| frameErr | output | 1 | Sticky flag for a misplaced sync |

## Verification
The embedded assertions check the rules that hold on every cycle. These are the one-hot strobe, `frameStart` appearing only together with channel A1, a zero tail below the kept length, the sticky error flag, silence before the first sync, and a strobe following each completion pulse from the control. The bench scenarios are the only way to show the rest. They cover slot placement in both framings, the exact cycle of each strobe, masking for every length code (including the 24-bit cut in split-frame mode), TDM slots 6 and 7 being dropped, and the behaviour after a short frame in each mode: the error flag, the suppressed right half, and clean recovery on the next frame.

// File: rtl/slot_audio_pkg.sv
package slot_audio_pkg;
  localparam int FRAME_BITS = 256;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int NUM_CH     = 6;
  localparam int CH_W       = 3;
  localparam int LEN_W      = 6;
  localparam int ONE_SLOT   = 24;
  localparam int TDM_SLOT   = 32;

  typedef struct packed {
    logic             first;    // first bit of a slot
    logic             shift;    // bit lies inside the kept length
    logic             done;     // last kept bit, and the frame is running
    logic [CH_W-1:0]  chan;     // channel index of the slot
    logic [LEN_W-1:0] lenBits;  // effective kept length
  } sadCtl_t;
endpackage

// File: rtl/slot_audio_ctrl.sv
module slot_audio_ctrl
  import slot_audio_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lrck,
  input  logic       modeTdm,
  input  logic [2:0] lenSel,
  output sadCtl_t    ctl,
  output logic       frameErr
);
  localparam logic [POS_W-1:0] HALF_POS = POS_W'(FRAME_BITS / 2);

  logic             lrckQ, tdmArm, locked, run, errQ;
  logic [POS_W-1:0] cnt, nextCnt, idx, syncIdx;
  logic             syncNow, mismatch, runEff;
  logic [LEN_W-1:0] lenBits;
  logic [6:0]       off;
  logic [CH_W-1:0]  slot;
  logic [LEN_W-1:0] bitPos;
  logic             inSlot;

  // length decode, clamped to the slot width in split-frame mode
  always_comb begin
    case (lenSel)
      3'd0:    lenBits = LEN_W'(16);
      3'd1:    lenBits = LEN_W'(18);
      3'd2:    lenBits = LEN_W'(20);
      3'd3:    lenBits = LEN_W'(24);
      default: lenBits = LEN_W'(32);
    endcase
    if (!modeTdm && lenBits > LEN_W'(ONE_SLOT)) lenBits = LEN_W'(ONE_SLOT);
  end

  // frame position tracking
  always_comb begin
    syncNow  = modeTdm ? tdmArm : (lrck != lrckQ);
    syncIdx  = (modeTdm || lrck) ? '0 : HALF_POS;
    nextCnt  = cnt + 1'b1;
    idx      = syncNow ? syncIdx : nextCnt;
    mismatch = syncNow && (nextCnt != syncIdx);
    if (syncNow && syncIdx == '0) runEff = 1'b1;
    else if (mismatch)            runEff = 1'b0;
    else                          runEff = run;
  end

  // slot decode for the bit captured now
  always_comb begin
    off    = idx[6:0];
    slot   = '0;
    bitPos = '0;
    inSlot = 1'b0;
    if (modeTdm) begin
      slot   = idx[7:5];
      bitPos = LEN_W'(idx[4:0]);
      inSlot = slot < CH_W'(NUM_CH);
    end else if (off < 7'd24) begin
      slot = 3'd0; bitPos = LEN_W'(off); inSlot = 1'b1;
    end else if (off < 7'd48) begin
      slot = 3'd1; bitPos = LEN_W'(off - 7'd24); inSlot = 1'b1;
    end else if (off < 7'd72) begin
      slot = 3'd2; bitPos = LEN_W'(off - 7'd48); inSlot = 1'b1;
    end
  end

  always_comb begin
    ctl.first   = inSlot && (bitPos == '0);
    ctl.shift   = inSlot && (bitPos < lenBits);
    ctl.done    = inSlot && runEff && (bitPos == lenBits - 1'b1);
    ctl.chan    = (!modeTdm && idx[7]) ? slot + 3'd3 : slot;
    ctl.lenBits = lenBits;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lrckQ  <= 1'b0;
      tdmArm <= 1'b0;
      cnt    <= '1;
      locked <= 1'b0;
      run    <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      lrckQ  <= lrck;
      tdmArm <= modeTdm && lrck && !lrckQ;
      cnt    <= idx;
      run    <= runEff;
      if (syncNow)            locked <= 1'b1;
      if (mismatch && locked) errQ   <= 1'b1;
    end
  end

  assign frameErr = errQ;

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> frameErr);
  a_r8_quiet_before_sync: assert property (@(posedge clk) disable iff (!rstN)
    !locked |-> !ctl.done);
  a_r6_done_in_length: assert property (@(posedge clk) disable iff (!rstN)
    ctl.done |-> ctl.shift && (ctl.chan < CH_W'(NUM_CH)));
endmodule

// File: rtl/slot_audio_dp.sv
module slot_audio_dp
  import slot_audio_pkg::*;
#(
  parameter int OUT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdin,
  input  sadCtl_t           ctl,
  output logic [OUT_W-1:0]  outData,
  output logic [NUM_CH-1:0] outValid,
  output logic              frameStart
);
  logic [OUT_W-1:0] acc, word;

  assign word = {acc[OUT_W-2:0], sdin};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc        <= '0;
      outData    <= '0;
      outValid   <= '0;
      frameStart <= 1'b0;
    end else begin
      if (ctl.first)      acc <= OUT_W'(sdin);
      else if (ctl.shift) acc <= word;
      if (ctl.done) begin
        outData    <= word << (OUT_W - int'(ctl.lenBits));
        outValid   <= NUM_CH'(1) << ctl.chan;
        frameStart <= (ctl.chan == '0);
      end else begin
        outValid   <= '0;
        frameStart <= 1'b0;
      end
    end
  end

  a_r6_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(outValid));
  a_r7_start_with_a1: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> outValid[0]);
  a_r5_zero_tail: assert property (@(posedge clk) disable iff (!rstN)
    ctl.done |=> ((outData << $past(ctl.lenBits)) == '0));
  a_r6_strobe_follows_done: assert property (@(posedge clk) disable iff (!rstN)
    ctl.done |=> (outValid != '0));
endmodule

// File: rtl/slot_audio_rx.sv
module slot_audio_rx
  import slot_audio_pkg::*;
#(
  parameter int OUT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lrck,
  input  logic              sdin,
  input  logic              modeTdm,
  input  logic [2:0]        lenSel,
  output logic [OUT_W-1:0]  outData,
  output logic [NUM_CH-1:0] outValid,
  output logic              frameStart,
  output logic              frameErr
);
  sadCtl_t ctl;

  slot_audio_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .lrck     (lrck),
    .modeTdm  (modeTdm),
    .lenSel   (lenSel),
    .ctl      (ctl),
    .frameErr (frameErr)
  );

  slot_audio_dp #(.OUT_W(OUT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sdin       (sdin),
    .ctl        (ctl),
    .outData    (outData),
    .outValid   (outValid),
    .frameStart (frameStart)
  );
endmodule

// File: tb/tb_slot_audio_rx.sv
module tb_slot_audio_rx;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lrck = 1'b0;
  logic        sdin = 1'b0;
  logic        modeTdm = 1'b0;
  logic [2:0]  lenSel = 3'd0;
  logic [31:0] outData;
  logic [5:0]  outValid;
  logic        frameStart;
  logic        frameErr;

  slot_audio_rx dut (
    .clk(clk), .rstN(rstN), .lrck(lrck), .sdin(sdin), .modeTdm(modeTdm),
    .lenSel(lenSel), .outData(outData), .outValid(outValid),
    .frameStart(frameStart), .frameErr(frameErr)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int curBit = 0;
  logic [31:0] smp [6];
  logic [31:0] gotData [6];
  int gotCnt [6];
  int gotAt [6];
  int startCnt = 0;
  int startBad = 0;
  logic [31:0] lfsr = 32'hACE1_2468;

  always @(posedge clk) begin
    #(CLK_P/4);
    if (rstN) begin
      for (int c = 0; c < 6; c++)
        if (outValid[c]) begin
          gotCnt[c]++;
          gotData[c] = outData;
          gotAt[c] = curBit;
        end
      if (frameStart) begin
        startCnt++;
        if (!outValid[0]) startBad++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  function automatic int effLen(input bit tdm, input int code);
    int l;
    case (code)
      0: l = 16; 1: l = 18; 2: l = 20; 3: l = 24; default: l = 32;
    endcase
    if (!tdm && l > 24) l = 24;
    return l;
  endfunction

  task automatic clearGot();
    for (int c = 0; c < 6; c++) begin
      gotCnt[c] = 0; gotData[c] = '0; gotAt[c] = -1;
    end
    startCnt = 0; startBad = 0;
  endtask

  // drive one frame of nBits bits; samples are taken from smp
  task automatic sendFrame(input bit tdm, input int nBits);
    int h;
    h = nBits / 2;
    for (int i = 0; i < nBits; i++) begin
      @(negedge clk);
      curBit = i;
      if (tdm) begin
        lrck = (i == nBits - 1);
        if (i / 32 < 6) sdin = smp[i / 32][31 - (i % 32)];
        else            sdin = nextRand() % 2 == 1;
      end else begin
        lrck = (i < h);
        if ((i % h) / 24 < 3) sdin = smp[(i / h) * 3 + (i % h) / 24][31 - ((i % h) % 24)];
        else                  sdin = nextRand() % 2 == 1;
      end
    end
  endtask

  task automatic idleBits(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lrck = 1'b0;
      sdin = nextRand() % 2 == 1;
    end
  endtask

  task automatic fillSamples();
    for (int c = 0; c < 6; c++) smp[c] = nextRand();
  endtask

  // compare strobes of a finished frame against the requirements
  task automatic checkFrame(input bit tdm, input int code, input bit wantA, input bit wantB, input int h);
    int l, expAt, want;
    logic [31:0] expD;
    l = effLen(tdm, code);
    for (int c = 0; c < 6; c++) begin
      want = (c < 3) ? int'(wantA) : int'(wantB);
      if (tdm) expAt = c * 32 + l - 1;
      else     expAt = (c / 3) * h + (c % 3) * 24 + l - 1;
      expD = smp[c] & (32'hFFFF_FFFF << (32 - l));
      if (want == 0) begin
        chk(gotCnt[c] == 0, "R10 no strobe after misplaced sync", gotCnt[c], 0);
      end else begin
        chk(gotCnt[c] == 1, tdm ? "R3 one strobe per slot" : "R2 one strobe per slot", gotCnt[c], 1);
        chk(gotData[c] == expD, "R4 R5 sample value", gotData[c], expD);
        chk(gotAt[c] == expAt, "R6 strobe cycle", gotAt[c], expAt);
      end
    end
    chk(startCnt == (wantA ? 1 : 0) && startBad == 0, "R7 frameStart with A1", startCnt, wantA ? 1 : 0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; lrck = 1'b0; sdin = 1'b0;
    repeat (3) @(negedge clk);
    chk(outValid == 0 && frameStart == 0 && frameErr == 0 && outData == 0,
        "R11 reset state", {outValid, frameStart, frameErr}, 0);
    rstN = 1'b1;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // ---------- split-frame mode ----------
    modeTdm = 1'b0;
    doReset();
    clearGot();
    idleBits(60);
    chk(gotCnt[0] + gotCnt[3] + startCnt == 0, "R8 silent before sync", gotCnt[0] + gotCnt[3], 0);
    for (int code = 0; code < 5; code++)
      for (int f = 0; f < 2; f++) begin
        lenSel = 3'(code);
        fillSamples();
        clearGot();
        sendFrame(1'b0, 256);
        checkFrame(1'b0, code, 1'b1, 1'b1, 128);
      end
    chk(frameErr == 1'b0, "R9 no error on clean frames", frameErr, 0);
    // short frame: falling edge at 100 instead of 128 (R9, R10)
    lenSel = 3'd1;
    fillSamples();
    clearGot();
    sendFrame(1'b0, 200);
    checkFrame(1'b0, 1, 1'b1, 1'b0, 100);
    chk(frameErr == 1'b1, "R9 misplaced edge sets error", frameErr, 1);
    fillSamples();
    clearGot();
    sendFrame(1'b0, 256);
    checkFrame(1'b0, 1, 1'b1, 1'b1, 128);
    chk(frameErr == 1'b1, "R9 error is sticky", frameErr, 1);

    // ---------- TDM mode ----------
    modeTdm = 1'b1;
    doReset();
    clearGot();
    idleBits(60);
    chk(gotCnt[0] + gotCnt[5] + startCnt == 0, "R8 silent before TDM sync", gotCnt[0] + gotCnt[5], 0);
    @(negedge clk);
    lrck = 1'b1; sdin = 1'b0;
    for (int code = 0; code < 6; code++)
      for (int f = 0; f < 2; f++) begin
        lenSel = (code == 5) ? 3'd7 : 3'(code);
        fillSamples();
        clearGot();
        sendFrame(1'b1, 256);
        checkFrame(1'b1, (code == 5) ? 7 : code, 1'b1, 1'b1, 128);
      end
    chk(frameErr == 1'b0, "R9 no TDM error on clean frames", frameErr, 0);
    // short frame: pulse at bit 199, next frame starts early
    lenSel = 3'd3;
    fillSamples();
    clearGot();
    sendFrame(1'b1, 200);
    checkFrame(1'b1, 3, 1'b1, 1'b1, 128);
    fillSamples();
    clearGot();
    sendFrame(1'b1, 256);
    checkFrame(1'b1, 3, 1'b1, 1'b1, 128);
    chk(frameErr == 1'b1, "R9 R1 early TDM sync flagged", frameErr, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule